// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbiter

This block is a clocked shared memory of 2048 bytes with two fully independent access ports, left and right. Each port has its own active-low select, write strobe and output gate, an 11-bit address, a write byte, a read byte and an active-low busy flag. Both ports may read any location at any time. When both selected ports sit on the same location and at least one of them writes, an arbiter grants the location to the port that got there first. It flags the other port busy, throws away that port's writes and freezes its read byte for as long as the flag is low.

Writes are posted. A write seen in one cycle is committed at the end of the next cycle, and only if that port's busy flag is high during that next cycle. Because the commit is gated by the same flag level that the pin shows, a second instance built with the slave option can take the first instance's busy outputs as its busy inputs. It then drops exactly the same writes, so two or more slices can form a wider word under one arbiter. In slave mode the built-in arbiter is absent and both busy outputs stay high.

Top module: `shared_ram_arb`

## Requirements
- R1: The memory holds 2^ADDR_W words (2048 at default) of DATA_W bits, and either port can reach every address. A read is a cycle with select low and write strobe high. The read byte shows the addressed word in the cycle after the read. It shows zero after any cycle in which that port was not reading with its output gate low.
- R2: A write is a cycle with both select and write strobe low. A read of that address presented in the very next cycle, by either port, already returns the new word.
- R3: Two ports reading the same address at the same time both get the stored word, and neither busy flag goes low.
- R4: If both ports are selected on one address and at least one is writing, the non-granted port's busy flag is low in the following cycle. It stays low while that condition lasts and returns high one cycle after the addresses differ or either select goes high.
- R5: The grant goes to the port that was already selected on that address in the previous cycle. If both or neither were, the left port wins. A grant holds until the match ends.
- R6: A write presented in cycle t is discarded when that port's busy flag is low in cycle t+1. Otherwise it is committed.
- R7: While a port's busy flag is low and it repeats the same read as in the previous cycle, its read byte keeps its previous value. The byte is refreshed as soon as the flag is high or the access pattern changes.
- R8: With the slave option, both busy outputs are constantly high, and the busy inputs take the role of the flags in R6 and R7.
- R9: After reset both busy flags are high and both read bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| l_ce_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output gate, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write byte |
| l_busy_in_n | input | 1 | Left busy input, active low, used with the slave option |
| l_rdata | output | DATA_W | Left read byte |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| r_ce_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output gate, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write byte |
| r_busy_in_n | input | 1 | Right busy input, active low, used with the slave option |
| r_rdata | output | DATA_W | Right read byte |
| r_busy_n | output | 1 | Right busy flag, active low, registered |

## Verification
The hardest state to reach is a losing port that keeps reading a location while the winner overwrites it. To get there, the winner must settle first, then start writing, and the flag must linger for one cycle after the winner leaves. Only then does the frozen byte give way to the new one. Directed sequences build this case, the same-cycle tie and the right-port-first grant. A slave instance, wired to the master's flags, shows whether its dropped writes line up. A constrained random phase on four shared addresses then produces dense overlaps of reads and writes, and a cycle model in the bench checks every output.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_act,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_act,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_busy_q,
   output logic              r_busy_q
);
   owner_e            owner_q, owner_d;
   logic              l_act_q, r_act_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   logic              match, wr_any, l_settled, r_settled;
   logic              l_busy_d, r_busy_d;

   always_comb begin
      match     = l_act && r_act && (l_addr == r_addr);
      wr_any    = l_wr || r_wr;
      l_settled = l_act_q && (l_addr_q == l_addr);
      r_settled = r_act_q && (r_addr_q == r_addr);
      owner_d   = OWN_NONE;
      if (match) begin
         if (owner_q != OWN_NONE)
            owner_d = owner_q;
         else if (r_settled && !l_settled)
            owner_d = OWN_RIGHT;
         else
            owner_d = OWN_LEFT;
      end
      l_busy_d = match && wr_any && (owner_d == OWN_RIGHT);
      r_busy_d = match && wr_any && (owner_d == OWN_LEFT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q  <= OWN_NONE;
         l_act_q  <= 1'b0;
         r_act_q  <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
         l_busy_q <= 1'b0;
         r_busy_q <= 1'b0;
      end else begin
         owner_q  <= owner_d;
         l_act_q  <= l_act;
         r_act_q  <= r_act;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
         l_busy_q <= l_busy_d;
         r_busy_q <= r_busy_d;
      end
   end

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !match |=> (!l_busy_q && !r_busy_q));

   p_reads_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !l_wr && !r_wr) |=> (!l_busy_q && !r_busy_q));

   p_left_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (match && wr_any && owner_q == OWN_NONE && !l_settled && !r_settled)
      |=> (r_busy_q && !l_busy_q));

   p_owner_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (match && owner_q != OWN_NONE) |=> (owner_q == $past(owner_q)));
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lose,
   output logic              act,
   output logic              wr,
   output logic              commit,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wword,
   output logic              upd,
   output logic              hold,
   output logic              out_en
);
   logic              rd;
   logic              pend_v_q, rd_q, oen_q;
   logic [ADDR_W-1:0] pend_addr_q, rd_addr_q;
   logic [DATA_W-1:0] pend_data_q;

   always_comb begin
      act    = !ce_n;
      wr     = act && !we_n;
      rd     = act && we_n;
      commit = pend_v_q && !lose;
      waddr  = pend_addr_q;
      wword  = pend_data_q;
      hold   = lose && rd && rd_q && (rd_addr_q == addr);
      upd    = rd && !hold;
      out_en = oen_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v_q    <= 1'b0;
         pend_addr_q <= '0;
         pend_data_q <= '0;
         rd_q        <= 1'b0;
         rd_addr_q   <= '0;
         oen_q       <= 1'b0;
      end else begin
         pend_v_q    <= wr;
         pend_addr_q <= addr;
         pend_data_q <= wdata;
         rd_q        <= rd;
         rd_addr_q   <= addr;
         oen_q       <= rd && !oe_n;
      end
   end

   p_drop_on_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lose |-> !commit);
endmodule

// File: rtl/dpr_store.sv
module dpr_store
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PORTS-1:0]                 commit,
   input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     waddr,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wdata,
   input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     raddr,
   input  logic [NUM_PORTS-1:0]                 upd,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]     word
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (commit[p])
            mem[waddr[p]] <= wdata[p];
      end
   end

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
      logic [DATA_W-1:0] nxt;
      logic [DATA_W-1:0] word_q;

      always_comb begin
         nxt = mem[raddr[g]];
         for (int q = 0; q < NUM_PORTS; q++) begin
            if (commit[q] && (waddr[q] == raddr[g]))
               nxt = wdata[q];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (upd[g])
            word_q <= nxt;
      end

      assign word[g] = word_q;
   end

   p_single_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit[0] && commit[1]) |-> (waddr[0] != waddr[1]));
endmodule

// File: rtl/shared_ram_arb.sv
module shared_ram_arb
   import dpr_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int DATA_W   = 8,
   parameter bit IS_SLAVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_we_n,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_in_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_busy_n,
   input  logic              r_ce_n,
   input  logic              r_we_n,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_in_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_busy_n
);
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
      $error("shared_ram_arb: ADDR_W out of range 2..16");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
      $error("shared_ram_arb: DATA_W out of range 1..64");
   end

   logic              l_act, l_wr, l_commit, l_upd, l_hold, l_out_en, l_lose;
   logic              r_act, r_wr, r_commit, r_upd, r_hold, r_out_en, r_lose;
   logic [ADDR_W-1:0] l_waddr, r_waddr;
   logic [DATA_W-1:0] l_wword, r_wword, l_word, r_word;
   logic [NUM_PORTS-1:0][DATA_W-1:0] word_arr;

   dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_l (
      .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .we_n(l_we_n), .oe_n(l_oe_n),
      .addr(l_addr), .wdata(l_wdata), .lose(l_lose), .act(l_act), .wr(l_wr),
      .commit(l_commit), .waddr(l_waddr), .wword(l_wword), .upd(l_upd),
      .hold(l_hold), .out_en(l_out_en)
   );

   dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_r (
      .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .we_n(r_we_n), .oe_n(r_oe_n),
      .addr(r_addr), .wdata(r_wdata), .lose(r_lose), .act(r_act), .wr(r_wr),
      .commit(r_commit), .waddr(r_waddr), .wword(r_wword), .upd(r_upd),
      .hold(r_hold), .out_en(r_out_en)
   );

   dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .commit({r_commit, l_commit}),
      .waddr({r_waddr, l_waddr}),
      .wdata({r_wword, l_wword}),
      .raddr({r_addr, l_addr}),
      .upd({r_upd, l_upd}),
      .word(word_arr)
   );

   assign l_word  = word_arr[0];
   assign r_word  = word_arr[1];
   assign l_rdata = l_out_en ? l_word : '0;
   assign r_rdata = r_out_en ? r_word : '0;

   if (IS_SLAVE) begin : g_slave
      logic arb_unused;
      assign arb_unused = ^{l_act, l_wr, r_act, r_wr};
      assign l_lose     = !l_busy_in_n;
      assign r_lose     = !r_busy_in_n;
      assign l_busy_n   = 1'b1;
      assign r_busy_n   = 1'b1;

      p_slave_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!l_busy_in_n || !r_busy_in_n) |-> !((!l_busy_in_n && l_commit) ||
                                              (!r_busy_in_n && r_commit)));
   end else begin : g_master
      logic busy_in_unused;
      logic l_busy_q, r_busy_q;
      assign busy_in_unused = l_busy_in_n ^ r_busy_in_n;

      dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
         .clk(clk), .rst_n(rst_n),
         .l_act(l_act), .l_wr(l_wr), .l_addr(l_addr),
         .r_act(r_act), .r_wr(r_wr), .r_addr(r_addr),
         .l_busy_q(l_busy_q), .r_busy_q(r_busy_q)
      );

      assign l_lose   = l_busy_q;
      assign r_lose   = r_busy_q;
      assign l_busy_n = !l_busy_q;
      assign r_busy_n = !r_busy_q;

      p_one_loser_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(!l_busy_n && !r_busy_n));
   end

   p_stale_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
      l_hold |=> $stable(l_word));

   p_stale_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r_hold |=> $stable(r_word));
endmodule

// File: tb/shared_ram_arb_bench.sv
module shared_ram_arb_bench;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0]    ce_n, we_n, oe_n;
   logic [AW-1:0] addr [2];
   logic [DW-1:0] mwd [2];
   logic [DW-1:0] swd [2];
   logic [DW-1:0] m_rd [2];
   logic [DW-1:0] s_rd [2];
   logic          m_bn [2];
   logic          s_bn [2];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   shared_ram_arb #(.ADDR_W(AW), .DATA_W(DW), .IS_SLAVE(1'b0)) u_shared_ram_arb (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(ce_n[0]), .l_we_n(we_n[0]), .l_oe_n(oe_n[0]), .l_addr(addr[0]),
      .l_wdata(mwd[0]), .l_busy_in_n(1'b1), .l_rdata(m_rd[0]), .l_busy_n(m_bn[0]),
      .r_ce_n(ce_n[1]), .r_we_n(we_n[1]), .r_oe_n(oe_n[1]), .r_addr(addr[1]),
      .r_wdata(mwd[1]), .r_busy_in_n(1'b1), .r_rdata(m_rd[1]), .r_busy_n(m_bn[1])
   );

   shared_ram_arb #(.ADDR_W(AW), .DATA_W(DW), .IS_SLAVE(1'b1)) u_shared_ram_arb_slave (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(ce_n[0]), .l_we_n(we_n[0]), .l_oe_n(oe_n[0]), .l_addr(addr[0]),
      .l_wdata(swd[0]), .l_busy_in_n(m_bn[0]), .l_rdata(s_rd[0]), .l_busy_n(s_bn[0]),
      .r_ce_n(ce_n[1]), .r_we_n(we_n[1]), .r_oe_n(oe_n[1]), .r_addr(addr[1]),
      .r_wdata(swd[1]), .r_busy_in_n(m_bn[1]), .r_rdata(s_rd[1]), .r_busy_n(s_bn[1])
   );

   // cycle model of the requirements; index d: 0 master, 1 slave
   logic [DW-1:0] em [2][DEPTH];
   logic [DW-1:0] e_word [2][2];
   logic [DW-1:0] e_pd [2][2];
   bit            e_oen [2], e_pv [2], e_rq [2], e_aq [2], e_busy [2];
   logic [AW-1:0] e_pa [2], e_ra [2], e_adq [2];
   int            e_own;

   function automatic logic [DW-1:0] pre_m(input int i);
      return DW'(i) ^ 8'h3C;
   endfunction
   function automatic logic [DW-1:0] pre_s(input int i);
      return DW'(i) ^ 8'hC3;
   endfunction

   task automatic model_reset();
      for (int p = 0; p < 2; p++) begin
         e_oen[p] = 0; e_pv[p] = 0; e_rq[p] = 0; e_aq[p] = 0; e_busy[p] = 0;
         e_pa[p] = '0; e_ra[p] = '0; e_adq[p] = '0;
         for (int d = 0; d < 2; d++) begin
            e_word[d][p] = '0;
            e_pd[d][p]   = '0;
         end
      end
      e_own = 0;
   endtask

   task automatic model_step();
      bit act [2], wr [2], rd [2], lose [2], st [2], bsy [2];
      bit match, hold;
      int own_d;
      for (int p = 0; p < 2; p++) begin
         act[p]  = !ce_n[p];
         wr[p]   = act[p] && !we_n[p];
         rd[p]   = act[p] && we_n[p];
         lose[p] = e_busy[p];
         st[p]   = e_aq[p] && (e_adq[p] == addr[p]);
      end
      match = act[0] && act[1] && (addr[0] == addr[1]);
      own_d = 0;
      if (match) begin
         if (e_own != 0) own_d = e_own;
         else if (st[1] && !st[0]) own_d = 2;
         else own_d = 1;
      end
      bsy[0] = match && (wr[0] || wr[1]) && (own_d == 2);
      bsy[1] = match && (wr[0] || wr[1]) && (own_d == 1);
      for (int d = 0; d < 2; d++)
         for (int p = 0; p < 2; p++)
            if (e_pv[p] && !lose[p]) em[d][e_pa[p]] = e_pd[d][p];
      for (int p = 0; p < 2; p++) begin
         hold = lose[p] && rd[p] && e_rq[p] && (e_ra[p] == addr[p]);
         for (int d = 0; d < 2; d++)
            if (rd[p] && !hold) e_word[d][p] = em[d][addr[p]];
         e_oen[p]   = rd[p] && !oe_n[p];
         e_pv[p]    = wr[p];
         e_pa[p]    = addr[p];
         e_pd[0][p] = mwd[p];
         e_pd[1][p] = swd[p];
         e_rq[p]    = rd[p];
         e_ra[p]    = addr[p];
         e_aq[p]    = act[p];
         e_adq[p]   = addr[p];
         e_busy[p]  = bsy[p];
      end
      e_own = own_d;
   endtask

   task automatic chk(input logic [31:0] actual, input logic [31:0] expected, input string tag);
      checks++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
      end
   endtask

   task automatic compare();
      for (int p = 0; p < 2; p++) begin
         chk(32'(m_rd[p]), 32'(e_oen[p] ? e_word[0][p] : '0), "R1 master read byte vs model");
         chk(32'(s_rd[p]), 32'(e_oen[p] ? e_word[1][p] : '0), "R1 slave read byte vs model");
         chk(32'(m_bn[p]), 32'(!e_busy[p]), "R4 master busy vs model");
         chk(32'(s_bn[p]), 32'd1, "R8 slave busy stays high");
      end
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int p);
      ce_n[p] = 1'b1; we_n[p] = 1'b1; oe_n[p] = 1'b1;
   endtask
   task automatic rdp(input int p, input int a);
      ce_n[p] = 1'b0; we_n[p] = 1'b1; oe_n[p] = 1'b0; addr[p] = AW'(a);
   endtask
   task automatic wrp(input int p, input int a, input logic [DW-1:0] md, input logic [DW-1:0] sd);
      ce_n[p] = 1'b0; we_n[p] = 1'b0; oe_n[p] = 1'b1; addr[p] = AW'(a);
      mwd[p] = md; swd[p] = sd;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd8675309));
      for (int p = 0; p < 2; p++) begin
         idle(p); addr[p] = '0; mwd[p] = '0; swd[p] = '0;
      end
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      for (int p = 0; p < 2; p++) begin
         chk(32'(m_bn[p]), 32'd1, "R9 busy high after reset");
         chk(32'(m_rd[p]), 32'd0, "R9 read byte zero after reset");
      end

      // prefill 0..15
      idle(1);
      for (int i = 0; i < 16; i++) begin
         wrp(0, i, pre_m(i), pre_s(i));
         cyc();
      end
      idle(0); cyc(); cyc();

      // R1: output gate high gives zero, then data
      rdp(0, 3); oe_n[0] = 1'b1; cyc();
      chk(32'(m_rd[0]), 32'd0, "R1 gate high reads zero");
      rdp(0, 3); cyc();
      chk(32'(m_rd[0]), 32'(pre_m(3)), "R1 read prefilled word");
      // R1/R2: top address, read next cycle from the other port
      wrp(0, DEPTH - 1, 8'hE7, 8'h7E); cyc();
      idle(0); rdp(1, DEPTH - 1); cyc();
      chk(32'(m_rd[1]), 32'hE7, "R1 top address reachable");
      // R2: write then read next cycle
      wrp(0, 5, 8'hA5, 8'h5A); idle(1); cyc();
      idle(0); rdp(1, 5); cyc();
      chk(32'(m_rd[1]), 32'hA5, "R2 write visible next cycle");
      chk(32'(s_rd[1]), 32'h5A, "R2 slave write visible next cycle");
      // R3: shared read
      rdp(0, 5); rdp(1, 5); cyc(); cyc();
      chk(32'(m_rd[0]), 32'hA5, "R3 left shared read");
      chk(32'(m_rd[1]), 32'hA5, "R3 right shared read");
      chk(32'(m_bn[0] & m_bn[1]), 32'd1, "R3 no busy on shared read");

      // R4/R5/R6: left settles, right writes into it
      idle(0); idle(1); cyc();
      rdp(0, 7); cyc();
      wrp(1, 7, 8'h77, 8'h88); cyc();
      chk(32'(m_bn[1]), 32'd0, "R4 late writer flagged");
      chk(32'(m_bn[0]), 32'd1, "R5 settled port keeps grant");
      chk(32'(s_bn[1]), 32'd1, "R8 slave busy output high");
      cyc();
      chk(32'(m_bn[1]), 32'd0, "R4 flag holds during collision");
      idle(1); cyc();
      chk(32'(m_bn[1]), 32'd1, "R4 flag releases");
      cyc();
      chk(32'(m_rd[0]), 32'(pre_m(7)), "R6 loser write discarded");
      chk(32'(s_rd[0]), 32'(pre_s(7)), "R8 slave discards same write");

      // R5: same-cycle tie, left wins
      idle(0); idle(1); cyc();
      wrp(0, 9, 8'h99, 8'h66); rdp(1, 9); cyc();
      chk(32'(m_bn[1]), 32'd0, "R5 tie right flagged");
      chk(32'(m_bn[0]), 32'd1, "R5 tie left granted");
      idle(0); idle(1); cyc();
      rdp(1, 9); cyc();
      chk(32'(m_rd[1]), 32'h99, "R5 tie winner write lands");
      chk(32'(s_rd[1]), 32'h66, "R8 slave winner write lands");

      // R5/R6: right settled first
      idle(1); cyc();
      rdp(1, 11); idle(0); cyc();
      wrp(0, 11, 8'hBB, 8'h44); cyc();
      chk(32'(m_bn[0]), 32'd0, "R5 right first left flagged");
      idle(0); idle(1); cyc();
      rdp(1, 11); cyc();
      chk(32'(m_rd[1]), 32'(pre_m(11)), "R6 left write discarded");

      // R7: stale read while winner writes
      idle(0); idle(1); cyc();
      rdp(1, 12); cyc();
      wrp(1, 12, 8'hCC, 8'hDD); rdp(0, 12); cyc();
      chk(32'(m_rd[0]), 32'(pre_m(12)), "R7 first read old word");
      chk(32'(m_bn[0]), 32'd0, "R4 reader flagged");
      cyc();
      chk(32'(m_rd[0]), 32'(pre_m(12)), "R7 stale while busy");
      cyc();
      chk(32'(m_rd[0]), 32'(pre_m(12)), "R7 still stale");
      idle(1); cyc();
      chk(32'(m_rd[0]), 32'(pre_m(12)), "R7 held while flag low");
      chk(32'(s_rd[0]), 32'(pre_s(12)), "R7 slave held while flag low");
      cyc();
      chk(32'(m_rd[0]), 32'hCC, "R7 refresh after release");
      chk(32'(s_rd[0]), 32'hDD, "R7 slave refresh after release");

      // random phase on four shared addresses
      for (int n = 0; n < 3000; n++) begin
         for (int p = 0; p < 2; p++) begin
            ce_n[p] = (($urandom % 4) == 0);
            we_n[p] = (($urandom % 3) != 0);
            oe_n[p] = (($urandom % 5) == 0);
            addr[p] = AW'($urandom % 4);
            mwd[p]  = DW'($urandom);
            swd[p]  = DW'($urandom);
         end
         cyc();
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule